// File: doc/BRIEF.md
# Serial NAND Page Read Sequencer

This block is the master side of a single-bit SPI link to a serial NAND flash, and it only reads. A request gives a starting byte address, a byte count and a one-cycle start pulse. The block cuts the request into whole pages and runs a fixed sequence for each page. It polls the device until it is idle, loads the page into the device's internal buffer, and polls again. It then reads the buffer from column zero and checks the device's ECC outcome for that page.

Page bytes leave the block on a valid/data pair, one byte for each valid pulse, with no back-pressure. When the request ends, the block raises a one-cycle done pulse together with a 2-bit outcome code. An uncorrectable page, or a device that stays busy past the programmable poll limit, aborts the rest of the request. A request that is not page aligned is refused before any SPI traffic starts.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, spi_cs_n is high, spi_sclk is low, and done and rd_valid are low.
- R2: The link uses SPI mode 0 with the most significant bit first. spi_sclk is low whenever spi_cs_n changes, and each transaction ends with spi_cs_n high for at least CS_GAP (at least 2) clock cycles.
- R3: A status read is one transaction of three bytes: 0x05, then 0xC0, then 0x00. The busy flag is bit 0 of the byte received during the third byte, and the read is repeated while that bit is 1.
- R4: For every page, exactly one busy wait happens before the load transaction and one after it, followed by the read transaction and then one ECC status read. A page with no busy time therefore costs five transactions.
- R5: The load transaction sends 0x13, then 0x00, then the 16-bit page index with the high byte first. The page index is start_addr divided by PAGE_BYTES.
- R6: The read transaction sends 0x0B and three 0x00 bytes, then clocks in PAGE_BYTES data bytes under the same chip select. Each data byte comes out as one rd_valid pulse, in order.
- R7: A request of N pages reads pages P, P+1, ... P+N-1 in that order.
- R8: The ECC code is bits 5:4 of the status byte read after each page. Codes 0 and 1 let the request continue.
- R9: ECC code 2 or 3 ends the request with outcome 2, and no further page is loaded.
- R10: If start_addr or byte_count is not a multiple of PAGE_BYTES, done rises in the cycle after start with outcome 1, and spi_cs_n never falls.
- R11: A busy wait issues at most max(poll_limit,1) status reads. If the last of them still shows busy, the request ends with outcome 3.
- R12: An aligned request with byte_count zero completes with outcome 0 in the cycle after start, with no SPI traffic.
- R13: done is a one-cycle pulse. status holds the outcome: 0 means ok, 1 misaligned, 2 ECC failure, 3 busy timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse; ignored while a request runs |
| start_addr | input | ADDR_W | Starting byte address |
| byte_count | input | CNT_W | Number of bytes to read |
| poll_limit | input | POLL_W | Maximum status reads per busy wait (0 acts as 1) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| rd_valid | output | 1 | Page data byte strobe |
| rd_data | output | 8 | Page data byte |
| done | output | 1 | Request finished pulse |
| status | output | 2 | Outcome code, valid with done |

## Verification
The hardest cases to reach are the abort paths in the middle of a request. An ECC failure on a page other than the first, or a device that stays busy long enough to exhaust the poll budget, cannot be forced through the block's own inputs. The bench therefore uses a behavioural flash model whose busy duration and ECC code are set for each scenario, and the ECC failure is placed on one chosen page of a multi-page request. The bench then counts the status reads, the loads and the data bytes that the model actually saw, and compares them with the exact number expected before the abort.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
   localparam int PIDX_W = 16;

   localparam logic [7:0] OPC_STATUS  = 8'h05;
   localparam logic [7:0] OPC_LOAD    = 8'h13;
   localparam logic [7:0] OPC_BUFREAD = 8'h0B;
   localparam logic [7:0] REG_GENERAL = 8'hC0;

   localparam int BUSY_BIT = 0;
   localparam int ECC_MSB  = 5;

   typedef enum logic [1:0] {
      RES_OK       = 2'd0,
      RES_MISALIGN = 2'd1,
      RES_ECC      = 2'd2,
      RES_TIMEOUT  = 2'd3
   } rd_result_e;

   typedef enum logic [2:0] {
      STEP_WAIT_PRE,
      STEP_LOAD,
      STEP_WAIT_POST,
      STEP_READ,
      STEP_ECC
   } rd_step_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_GAP,
      SQ_XFER
   } seq_state_e;
endpackage

// File: rtl/nand_spi_byte.sv
module nand_spi_byte #(
   parameter int CLK_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic       fin,
   output logic [7:0] rx
);
   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   logic       active;
   logic       hi;
   logic       tick;
   logic [2:0] bitn;
   logic [7:0] sh;
   logic [7:0] rsh;

   // Divider variant: one half-period of sclk lasts CLK_DIV clocks
   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = active;
      end else begin : g_div
         logic [DIV_W-1:0] divc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               divc <= '0;
            else if (!active || divc == DIV_W'(CLK_DIV - 1))
               divc <= '0;
            else
               divc <= divc + DIV_W'(1);
         end
         assign tick = active && (divc == DIV_W'(CLK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         hi     <= 1'b0;
         bitn   <= '0;
         sh     <= '0;
         rsh    <= '0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (!active) begin
            if (go) begin
               active <= 1'b1;
               sh     <= tx;
               bitn   <= '0;
               hi     <= 1'b0;
            end
         end else if (tick) begin
            if (!hi) begin
               hi  <= 1'b1;
               rsh <= {rsh[6:0], miso};
            end else begin
               hi   <= 1'b0;
               sh   <= {sh[6:0], 1'b0};
               bitn <= bitn + 3'd1;
               if (bitn == 3'd7) begin
                  active <= 1'b0;
                  fin    <= 1'b1;
               end
            end
         end
      end
   end

   assign sclk = hi;
   assign mosi = sh[7];
   assign rx   = rsh;
endmodule

// File: rtl/nand_req_check.sv
module nand_req_check
   import nand_rd_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 24,
   parameter int PAGE_BYTES = 2048
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  cnt,
   output logic              misaligned,
   output logic              empty,
   output logic [PIDX_W-1:0] first_page,
   output logic [CNT_W-1:0]  n_pages
);
   localparam int PG_LG = $clog2(PAGE_BYTES);

   always_comb begin
      misaligned = (addr[PG_LG-1:0] != '0) || (cnt[PG_LG-1:0] != '0);
      empty      = (cnt == '0);
      first_page = PIDX_W'(addr >> PG_LG);
      n_pages    = cnt >> PG_LG;
   end
endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
   import nand_rd_pkg::*;
#(
   parameter int PAGE_BYTES = 2048,
   parameter int CNT_W      = 24,
   parameter int POLL_W     = 16,
   parameter int CS_GAP     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              misaligned,
   input  logic              empty,
   input  logic [PIDX_W-1:0] first_page,
   input  logic [CNT_W-1:0]  n_pages,
   input  logic [POLL_W-1:0] poll_limit,
   output logic              cs_n,
   output logic              go,
   output logic [7:0]        tx,
   input  logic              fin,
   input  logic [7:0]        rx,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              done,
   output logic [1:0]        status
);
   localparam int BI_W  = $clog2(PAGE_BYTES + 4) + 1;
   localparam int GAP_W = $clog2(CS_GAP + 1);
   localparam logic [BI_W-1:0] LAST_STAT = BI_W'(2);
   localparam logic [BI_W-1:0] LAST_LOAD = BI_W'(3);
   localparam logic [BI_W-1:0] LAST_READ = BI_W'(PAGE_BYTES + 3);
   localparam logic [BI_W-1:0] HDR_LAST  = BI_W'(3);

   seq_state_e        state;
   rd_step_e          step;
   logic [BI_W-1:0]   bidx;
   logic [GAP_W-1:0]  gapc;
   logic [PIDX_W-1:0] page;
   logic [CNT_W-1:0]  left;
   logic [POLL_W-1:0] polls;
   logic [POLL_W-1:0] lim;
   logic [BI_W-1:0]   last_idx;

   assign lim = (poll_limit == '0) ? POLL_W'(1) : poll_limit;

   function automatic logic [7:0] frame_byte(rd_step_e s, logic [BI_W-1:0] i,
                                             logic [PIDX_W-1:0] pg);
      logic [7:0] b;
      b = 8'h00;
      case (s)
         STEP_LOAD: begin
            if (i == BI_W'(0))      b = OPC_LOAD;
            else if (i == BI_W'(2)) b = pg[15:8];
            else if (i == BI_W'(3)) b = pg[7:0];
         end
         STEP_READ: begin
            if (i == BI_W'(0)) b = OPC_BUFREAD;
         end
         default: begin
            if (i == BI_W'(0))      b = OPC_STATUS;
            else if (i == BI_W'(1)) b = REG_GENERAL;
         end
      endcase
      return b;
   endfunction

   always_comb begin
      case (step)
         STEP_LOAD: last_idx = LAST_LOAD;
         STEP_READ: last_idx = LAST_READ;
         default:   last_idx = LAST_STAT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         step     <= STEP_WAIT_PRE;
         cs_n     <= 1'b1;
         go       <= 1'b0;
         tx       <= '0;
         bidx     <= '0;
         gapc     <= '0;
         page     <= '0;
         left     <= '0;
         polls    <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
         done     <= 1'b0;
         status   <= RES_OK;
      end else begin
         go       <= 1'b0;
         rd_valid <= 1'b0;
         done     <= 1'b0;
         case (state)
            SQ_IDLE: begin
               if (start) begin
                  if (misaligned || empty) begin
                     done   <= 1'b1;
                     status <= misaligned ? RES_MISALIGN : RES_OK;
                  end else begin
                     page  <= first_page;
                     left  <= n_pages;
                     step  <= STEP_WAIT_PRE;
                     polls <= '0;
                     gapc  <= '0;
                     state <= SQ_GAP;
                  end
               end
            end
            SQ_GAP: begin
               if (gapc == GAP_W'(CS_GAP - 1)) begin
                  state <= SQ_XFER;
                  cs_n  <= 1'b0;
                  bidx  <= '0;
                  go    <= 1'b1;
                  tx    <= frame_byte(step, '0, page);
               end else begin
                  gapc <= gapc + GAP_W'(1);
               end
            end
            SQ_XFER: begin
               if (fin) begin
                  if (step == STEP_READ && bidx > HDR_LAST) begin
                     rd_valid <= 1'b1;
                     rd_data  <= rx;
                  end
                  if (bidx != last_idx) begin
                     bidx <= bidx + BI_W'(1);
                     go   <= 1'b1;
                     tx   <= frame_byte(step, bidx + BI_W'(1), page);
                  end else begin
                     cs_n  <= 1'b1;
                     gapc  <= '0;
                     state <= SQ_GAP;
                     case (step)
                        STEP_WAIT_PRE, STEP_WAIT_POST: begin
                           if (rx[BUSY_BIT]) begin
                              if (polls >= lim - POLL_W'(1)) begin
                                 done   <= 1'b1;
                                 status <= RES_TIMEOUT;
                                 state  <= SQ_IDLE;
                              end else begin
                                 polls <= polls + POLL_W'(1);
                              end
                           end else begin
                              polls <= '0;
                              step  <= (step == STEP_WAIT_PRE) ? STEP_LOAD : STEP_READ;
                           end
                        end
                        STEP_LOAD: step <= STEP_WAIT_POST;
                        STEP_READ: step <= STEP_ECC;
                        default: begin
                           if (rx[ECC_MSB]) begin
                              done   <= 1'b1;
                              status <= RES_ECC;
                              state  <= SQ_IDLE;
                           end else if (left == CNT_W'(1)) begin
                              done   <= 1'b1;
                              status <= RES_OK;
                              state  <= SQ_IDLE;
                           end else begin
                              left <= left - CNT_W'(1);
                              page <= page + PIDX_W'(1);
                              step <= STEP_WAIT_PRE;
                           end
                        end
                     endcase
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
   import nand_rd_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 24,
   parameter int POLL_W     = 16,
   parameter int PAGE_BYTES = 2048,
   parameter int CLK_DIV    = 2,
   parameter int CS_GAP     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  byte_count,
   input  logic [POLL_W-1:0] poll_limit,
   output logic              spi_sclk,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              done,
   output logic [1:0]        status
);
   localparam int PG_LG = $clog2(PAGE_BYTES);

   if (PAGE_BYTES < 8 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 8");
   end
   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end
   if (CS_GAP < 2) begin : g_bad_gap
      $error("CS_GAP must be at least 2");
   end
   if (ADDR_W <= PG_LG || CNT_W <= PG_LG) begin : g_bad_width
      $error("ADDR_W and CNT_W must exceed the page offset width");
   end
   if (POLL_W < 1) begin : g_bad_poll
      $error("POLL_W must be at least 1");
   end

   logic              misaligned;
   logic              empty;
   logic [PIDX_W-1:0] first_page;
   logic [CNT_W-1:0]  n_pages;
   logic              go;
   logic [7:0]        tx;
   logic              fin;
   logic [7:0]        rx;

   nand_req_check #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)
   ) u_req (
      .addr(start_addr), .cnt(byte_count), .misaligned(misaligned),
      .empty(empty), .first_page(first_page), .n_pages(n_pages)
   );

   nand_rd_seq #(
      .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W), .POLL_W(POLL_W), .CS_GAP(CS_GAP)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .misaligned(misaligned),
      .empty(empty), .first_page(first_page), .n_pages(n_pages),
      .poll_limit(poll_limit), .cs_n(spi_cs_n), .go(go), .tx(tx),
      .fin(fin), .rx(rx), .rd_valid(rd_valid), .rd_data(rd_data),
      .done(done), .status(status)
   );

   nand_spi_byte #(
      .CLK_DIV(CLK_DIV)
   ) u_phy (
      .clk(clk), .rst_n(rst_n), .go(go), .tx(tx), .miso(spi_miso),
      .sclk(spi_sclk), .mosi(spi_mosi), .fin(fin), .rx(rx)
   );
endmodule

// File: rtl/nand_page_reader_chk.sv
module nand_page_reader_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       spi_sclk,
   input logic       spi_cs_n,
   input logic       rd_valid,
   input logic       done,
   input logic [1:0] status
);
   assert_sclk_inside_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |-> !spi_cs_n);

   assert_select_edge_sclk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> !spi_sclk);

   assert_min_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |=> spi_cs_n);

   assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (spi_cs_n && !spi_sclk));

   assert_data_before_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !done);

   assert_misalign_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd1) |-> $past(start));
endmodule

bind nand_page_reader nand_page_reader_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .spi_sclk(spi_sclk),
   .spi_cs_n(spi_cs_n), .rd_valid(rd_valid), .done(done), .status(status)
);

// File: tb/nand_page_reader_test.sv
module nand_page_reader_test;
   localparam int PB = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_addr = '0;
   logic [23:0] byte_count = '0;
   logic [15:0] poll_limit = 16'd8;
   logic        spi_sclk, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic        done;
   logic [1:0]  status;

   always #4 clk = ~clk;

   nand_page_reader #(
      .ADDR_W(32), .CNT_W(24), .POLL_W(16), .PAGE_BYTES(PB), .CLK_DIV(1), .CS_GAP(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .byte_count(byte_count), .poll_limit(poll_limit), .spi_sclk(spi_sclk),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .status(status)
   );

   int checks = 0;
   int fails = 0;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- behavioural flash model ----------------
   logic [7:0]  m_rx, m_tx, m_op;
   logic [15:0] m_pg, cur_page;
   int m_bit, m_byte;
   int busy_left, load_busy, ecc_page, ecc_val;
   int n_cs, n_stat, n_load, model_err;
   int load_log [0:15];

   function automatic logic [7:0] pat(int pg, int col);
      return 8'((pg * 13) ^ (col * 5 + 1));
   endfunction

   task model_byte_end();
      m_tx = 8'h00;
      if (m_byte == 0) begin
         m_op = m_rx;
      end else if (m_op == 8'h05) begin
         if (m_byte == 1) begin
            if (m_rx != 8'hC0) model_err++;
            n_stat++;
            m_tx = {2'b00, (int'(cur_page) == ecc_page) ? 2'(ecc_val) : 2'b00,
                    3'b000, busy_left > 0};
            if (busy_left > 0) busy_left--;
         end
      end else if (m_op == 8'h13) begin
         if (m_byte == 1 && m_rx != 8'h00) model_err++;
         if (m_byte == 2) m_pg[15:8] = m_rx;
         if (m_byte == 3) m_pg[7:0] = m_rx;
      end else if (m_op == 8'h0B) begin
         if (m_byte >= 1 && m_byte <= 3 && m_rx != 8'h00) model_err++;
         if (m_byte >= 3) m_tx = pat(int'(cur_page), m_byte - 3);
      end else begin
         model_err++;
      end
   endtask

   always @(negedge spi_cs_n) begin
      n_cs++;
      m_bit = 0;
      m_byte = 0;
      m_tx = 8'h00;
      spi_miso = 1'b0;
   end

   always @(posedge spi_cs_n) begin
      if (m_op == 8'h13 && m_byte == 4) begin
         cur_page = m_pg;
         busy_left = load_busy;
         load_log[n_load % 16] = int'(m_pg);
         n_load++;
      end
      m_op = 8'h00;
   end

   always @(posedge spi_sclk) begin
      if (!spi_cs_n) begin
         m_rx = {m_rx[6:0], spi_mosi};
         m_bit++;
         if (m_bit % 8 == 0) begin
            model_byte_end();
            m_byte++;
         end
      end
   end

   always @(negedge spi_sclk) begin
      if (!spi_cs_n) spi_miso = m_tx[3'(7 - (m_bit % 8))];
   end

   // ---------------- output observers ----------------
   int n_rx, rx_bad, exp_first;
   int hi_run = 0;
   int min_gap = 1000;

   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (rd_data !== pat(exp_first + n_rx / PB, n_rx % PB)) rx_bad++;
         n_rx++;
      end
      if (spi_cs_n) hi_run++;
      else begin
         if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
         hi_run = 0;
      end
   end

   int res_st, res_cyc;

   task automatic run_req(int addr, int cnt, int lim, int pre, int lb, int ep, int ev);
      busy_left = pre; load_busy = lb; ecc_page = ep; ecc_val = ev;
      exp_first = addr / PB; n_rx = 0; rx_bad = 0; n_stat = 0; n_load = 0;
      n_cs = 0; model_err = 0;
      @(negedge clk);
      start_addr = 32'(addr); byte_count = 24'(cnt); poll_limit = 16'(lim);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      res_cyc = 1;
      while (!done && res_cyc < 40000) begin
         @(negedge clk);
         res_cyc++;
      end
      res_st = int'(status);
      chk("R13 request completes", int'(done), 1);
      @(negedge clk);
      chk("R13 done lasts one cycle", int'(done), 0);
   endtask

   task automatic t_reset();
      chk("R1 cs_n high", int'(spi_cs_n), 1);
      chk("R1 sclk low", int'(spi_sclk), 0);
      chk("R1 done low", int'(done), 0);
      chk("R1 rd_valid low", int'(rd_valid), 0);
   endtask

   task automatic t_single();
      run_req(3 * PB, PB, 8, 0, 0, -1, 0);
      chk("R13 ok outcome", res_st, 0);
      chk("R6 byte count", n_rx, PB);
      chk("R6 data values", rx_bad, 0);
      chk("R5 one load", n_load, 1);
      chk("R5 page index", load_log[0], 3);
      chk("R3 status reads", n_stat, 3);
      chk("R4 five transactions", n_cs, 5);
      chk("R3 R5 R6 frame bytes", model_err, 0);
   endtask

   task automatic t_multi();
      run_req(16'h0102 * PB, 3 * PB, 8, 2, 1, -1, 0);
      chk("R13 ok outcome multi", res_st, 0);
      chk("R7 loads", n_load, 3);
      chk("R5 R7 first page msb first", load_log[0], 16'h0102);
      chk("R7 second page", load_log[1], 16'h0103);
      chk("R7 third page", load_log[2], 16'h0104);
      chk("R6 multi byte count", n_rx, 3 * PB);
      chk("R6 R7 multi data", rx_bad, 0);
      chk("R3 R4 busy polls", n_stat, 14);
      chk("R3 frame bytes multi", model_err, 0);
      chk("R2 deselect gap >= 2", int'(min_gap >= 2), 1);
   endtask

   task automatic t_ecc_corrected();
      run_req(5 * PB, PB, 8, 0, 0, 5, 1);
      chk("R8 code 1 accepted", res_st, 0);
      chk("R8 data delivered", n_rx, PB);
   endtask

   task automatic t_ecc_fail_mid();
      run_req(10 * PB, 3 * PB, 8, 0, 0, 11, 2);
      chk("R9 code 2 outcome", res_st, 2);
      chk("R9 no third load", n_load, 2);
      chk("R9 bytes before abort", n_rx, 2 * PB);
      chk("R9 data before abort", rx_bad, 0);
   endtask

   task automatic t_ecc_code3();
      run_req(20 * PB, PB, 8, 0, 0, 20, 3);
      chk("R9 code 3 outcome", res_st, 2);
   endtask

   task automatic t_misalign();
      run_req(2 * PB + 4, PB, 8, 0, 0, -1, 0);
      chk("R10 addr outcome", res_st, 1);
      chk("R10 addr latency", res_cyc, 1);
      chk("R10 addr no traffic", n_cs, 0);
      run_req(0, PB + 1, 8, 0, 0, -1, 0);
      chk("R10 count outcome", res_st, 1);
      chk("R10 count latency", res_cyc, 1);
      chk("R10 count no traffic", n_cs, 0);
   endtask

   task automatic t_timeout();
      run_req(7 * PB, PB, 4, 0, 100, -1, 0);
      chk("R11 timeout outcome", res_st, 3);
      chk("R11 poll budget", n_stat, 5);
      chk("R11 no data", n_rx, 0);
      run_req(8 * PB, PB, 0, 5, 0, -1, 0);
      chk("R11 zero limit outcome", res_st, 3);
      chk("R11 zero limit one poll", n_stat, 1);
      chk("R11 zero limit no load", n_load, 0);
   endtask

   task automatic t_zero();
      run_req(4 * PB, 0, 8, 0, 0, -1, 0);
      chk("R12 empty outcome", res_st, 0);
      chk("R12 empty latency", res_cyc, 1);
      chk("R12 empty no traffic", n_cs, 0);
   endtask

   initial begin
      m_op = 8'h00; m_tx = 8'h00; m_rx = 8'h00; m_pg = '0; cur_page = '0;
      m_bit = 0; m_byte = 0; busy_left = 0; load_busy = 0;
      ecc_page = -1; ecc_val = 0; n_cs = 0; n_stat = 0; n_load = 0; model_err = 0;
      n_rx = 0; rx_bad = 0; exp_first = 0;
      for (int i = 0; i < 16; i++) load_log[i] = -1;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_single();
      t_multi();
      t_ecc_corrected();
      t_ecc_fail_mid();
      t_ecc_code3();
      t_misalign();
      t_timeout();
      t_zero();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 190000);
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule